// File: doc/BRIEF.md
# Arbitrary-Ratio Bit Gearbox

The block converts a stream of fixed-width input words into a stream of fixed-width output words of another width, where neither width needs to be a multiple of the other. Incoming bits go into a circular bit store and are taken out in output-sized slices. The bits come out in exactly the order they went in.

Both sides use a valid/ready handshake. The block accepts an input word only when the store has room for all of its bits. It offers an output word only when the store holds at least a full output word. The write pointer and the read pointer move only when their handshake completes. When the two pointers are equal, a tag recording the last single-sided operation tells a full store from an empty one. A state that should not be reachable raises a fault flag that stays set until reset.

The store length must be at least the sum of the two widths, so that one side can always make progress.

Top module: `bit_gearbox`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1 and fault_o is 0.
- R2: in_ready_o is 1 exactly when the number of free bits in the store (DEPTH minus the bits held) is at least IN_W.
- R3: out_valid_o is 1 exactly when the number of bits held is at least OUT_W.
- R4: A write takes place on a clock edge where in_valid_i and in_ready_o are both 1, and it appends all IN_W bits of in_data_i, bit 0 first. When in_valid_i is 1 and in_ready_o is 0, the word is ignored and the held bit count does not change.
- R5: A read takes place on a clock edge where out_valid_o and out_ready_i are both 1, and it removes OUT_W bits. out_data_o bit 0 is the oldest held bit. Across any pattern of stalls, the concatenated output stream equals the concatenated input stream.
- R6: When the held count reaches DEPTH through writes, the pointers are equal, and the store reports full: in_ready_o is 0 and out_valid_o is 1. When a read brings the held count to 0, the pointers are also equal, and the store reports empty: out_valid_o is 0 and in_ready_o is 1.
- R7: When a read and a write happen on the same edge, both take effect, and the held count changes by IN_W minus OUT_W.
- R8: fault_o is registered and sticky until reset. It stays 0 for any sequence of legal handshakes.
- R9: While out_valid_o is 1 and out_ready_i is 0, on the next cycle out_valid_o stays 1 and out_data_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input word present |
| in_ready_o | output | 1 | Store has room for a full input word |
| in_data_i | input | IN_W | Input word, bit 0 earliest in the stream |
| out_valid_o | output | 1 | Full output word available |
| out_ready_i | input | 1 | Downstream accepts the output word |
| out_data_o | output | OUT_W | Output word, bit 0 oldest held bit |
| fault_o | output | 1 | Sticky fault on an impossible pointer/tag state |

## Verification
The bench first applies a directed fill with the output stalled, which drives the pointers equal in the full state. A directed drain follows, which makes them equal in the empty state; these two runs tell apart the two meanings of equal pointers. Random phases then cover four traffic patterns. Heavy traffic on both sides exposes errors in simultaneous read and write. A slow producer keeps the store near empty, which tests the valid-bit threshold. A slow consumer keeps it near full, which tests the free-bit threshold and the data hold under stall. Continuous traffic makes the pointers wrap repeatedly over the non-power-of-two ring length. Every cycle, a bit-queue model predicts ready, valid and the exact output bits.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  typedef enum logic [1:0] {
    LAST_RD  = 2'd0,
    LAST_WR  = 2'd1,
    LAST_UNK = 2'd2
  } last_op_e;
endpackage

// File: rtl/gbx_ptr.sv
module gbx_ptr #(
  parameter int DEPTH = 12,
  parameter int STEP  = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W:0] sum;
  logic [PTR_W-1:0] nxt;

  always_comb begin
    sum = {1'b0, ptr_o} + (PTR_W+1)'(STEP);
    if (sum >= (PTR_W+1)'(DEPTH)) sum = sum - (PTR_W+1)'(DEPTH);
    nxt = sum[PTR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= nxt;
  end
endmodule

// File: rtl/gbx_occupancy.sv
module gbx_occupancy
  import gbx_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int IN_W  = 6,
  parameter int OUT_W = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  input  last_op_e         last_op_i,
  output logic [CNT_W-1:0] held_o,
  output logic [CNT_W-1:0] free_o,
  output logic             can_wr_o,
  output logic             can_rd_o,
  output logic             bad_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] w, r;
  logic             range_bad;

  assign w = CNT_W'(wr_ptr_i);
  assign r = CNT_W'(rd_ptr_i);
  assign range_bad = (w >= DEPTH_C) || (r >= DEPTH_C);

  always_comb begin
    bad_o  = range_bad;
    held_o = '0;
    if (w > r)      held_o = w - r;
    else if (r > w) held_o = DEPTH_C - r + w;
    else begin
      unique case (last_op_i)
        LAST_WR: held_o = DEPTH_C;
        LAST_RD: held_o = '0;
        default: bad_o  = 1'b1;
      endcase
    end
    free_o   = DEPTH_C - held_o;
    can_wr_o = !bad_o && (free_o >= CNT_W'(IN_W));
    can_rd_o = !bad_o && (held_o >= CNT_W'(OUT_W));
  end
endmodule

// File: rtl/gbx_ring.sv
module gbx_ring #(
  parameter int DEPTH = 12,
  parameter int IN_W  = 6,
  parameter int OUT_W = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  logic [IN_W-1:0]  wr_data_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output logic [OUT_W-1:0] rd_data_o
);
  logic [DEPTH-1:0] mem_q, mem_d;
  logic [DEPTH-1:0] wr_pad;

  assign wr_pad = DEPTH'(wr_data_i);

  // per store bit: offset into the incoming word, wrap-aware
  for (genvar j = 0; j < DEPTH; j++) begin : g_wr
    logic [PTR_W:0] off;
    always_comb begin
      if ((PTR_W+1)'(j) >= {1'b0, wr_ptr_i}) off = (PTR_W+1)'(j) - {1'b0, wr_ptr_i};
      else off = (PTR_W+1)'(j) + (PTR_W+1)'(DEPTH) - {1'b0, wr_ptr_i};
      mem_d[j] = (wr_en_i && off < (PTR_W+1)'(IN_W)) ? wr_pad[off[PTR_W-1:0]] : mem_q[j];
    end
  end

  for (genvar k = 0; k < OUT_W; k++) begin : g_rd
    logic [PTR_W:0] idx;
    always_comb begin
      idx = {1'b0, rd_ptr_i} + (PTR_W+1)'(k);
      if (idx >= (PTR_W+1)'(DEPTH)) idx = idx - (PTR_W+1)'(DEPTH);
      rd_data_o[k] = mem_q[idx[PTR_W-1:0]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else         mem_q <= mem_d;
  end
endmodule

// File: rtl/bit_gearbox.sv
module bit_gearbox
  import gbx_pkg::*;
#(
  parameter int IN_W  = 6,
  parameter int OUT_W = 4,
  parameter int DEPTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [IN_W-1:0]  in_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [OUT_W-1:0] out_data_o,
  output logic             fault_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  initial begin
    if (DEPTH < IN_W + OUT_W) $error("DEPTH must be at least IN_W + OUT_W");
  end

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] held, free;
  logic             can_wr, can_rd, bad;
  logic             wr_go, rd_go;
  last_op_e         last_op_q;
  logic             fault_q;

  assign in_ready_o  = can_wr;
  assign out_valid_o = can_rd;
  assign wr_go       = in_valid_i && can_wr;
  assign rd_go       = out_ready_i && can_rd;
  assign fault_o     = fault_q;

  gbx_occupancy #(.DEPTH(DEPTH), .IN_W(IN_W), .OUT_W(OUT_W)) occ_i (
    .wr_ptr_i (wr_ptr),
    .rd_ptr_i (rd_ptr),
    .last_op_i(last_op_q),
    .held_o   (held),
    .free_o   (free),
    .can_wr_o (can_wr),
    .can_rd_o (can_rd),
    .bad_o    (bad)
  );

  gbx_ptr #(.DEPTH(DEPTH), .STEP(IN_W)) wptr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(wr_go), .ptr_o(wr_ptr)
  );

  gbx_ptr #(.DEPTH(DEPTH), .STEP(OUT_W)) rptr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(rd_go), .ptr_o(rd_ptr)
  );

  gbx_ring #(.DEPTH(DEPTH), .IN_W(IN_W), .OUT_W(OUT_W)) ring_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_go),
    .wr_ptr_i (wr_ptr),
    .wr_data_i(in_data_i),
    .rd_ptr_i (rd_ptr),
    .rd_data_o(out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_op_q <= LAST_RD;
      fault_q   <= 1'b0;
    end else begin
      if (wr_go && !rd_go)      last_op_q <= LAST_WR;
      else if (rd_go && !wr_go) last_op_q <= LAST_RD;
      if (bad) fault_q <= 1'b1;
    end
  end

  assert_idle_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_go && !rd_go) |=> (held == $past(held)));

  assert_dual_delta_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && rd_go) |=> (int'(held) == int'($past(held)) + IN_W - OUT_W));

  assert_full_state_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held == CNT_W'(DEPTH)) |-> (!in_ready_o && out_valid_o));

  assert_fault_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);

  assert_out_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  assert_free_ok_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(held) + int'(free) == DEPTH) && (held <= CNT_W'(DEPTH)));
endmodule

// File: tb/bit_gearbox_tb_top.sv
`timescale 1ns/1ps
module bit_gearbox_tb_top;
  localparam int IN_W  = 6;
  localparam int OUT_W = 4;
  localparam int DEPTH = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [IN_W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [OUT_W-1:0] out_data;
  logic fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit q[$];
  bit last_dual = 1'b0;

  always #2 clk = ~clk;

  bit_gearbox #(.IN_W(IN_W), .OUT_W(OUT_W), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .fault_o(fault)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_ready(int held);
    return (DEPTH - held) >= IN_W;
  endfunction

  function automatic logic exp_valid(int held);
    return held >= OUT_W;
  endfunction

  function automatic logic [OUT_W-1:0] exp_word();
    logic [OUT_W-1:0] w = '0;
    for (int k = 0; k < OUT_W; k++) w[k] = q[k];
    return w;
  endfunction

  // compare outputs at negedge, then drive new inputs, then apply the edge to the model
  task automatic step(input int p_in, input int p_out);
    bit wf, rf;
    int h;
    @(negedge clk);
    h = q.size();
    check(in_ready == exp_ready(h), last_dual ? "R7 in_ready" : "R2 in_ready", 32'(in_ready), 32'(exp_ready(h)));
    check(out_valid == exp_valid(h), last_dual ? "R7 out_valid" : "R3 out_valid", 32'(out_valid), 32'(exp_valid(h)));
    if (h >= OUT_W) check(out_data == exp_word(), "R5 out_data", 32'(out_data), 32'(exp_word()));
    check(fault == 1'b0, "R8 fault", 32'(fault), 32'd0);
    in_valid  = ($urandom % 100) < p_in;
    in_data   = IN_W'($urandom);
    out_ready = ($urandom % 100) < p_out;
    wf = in_valid && in_ready;
    rf = out_ready && out_valid;
    @(posedge clk);
    if (rf) for (int k = 0; k < OUT_W; k++) void'(q.pop_front());
    if (wf) for (int k = 0; k < IN_W; k++) q.push_back(in_data[k]);
    last_dual = wf && rf;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
    check(fault == 1'b0, "R1 fault", 32'(fault), 32'd0);
    rst_n = 1'b1;

    // directed fill: two writes reach DEPTH bits, third offer is refused (R4)
    repeat (3) step(100, 0);
    @(negedge clk);
    check(q.size() == DEPTH, "R4 held after fill", 32'(q.size()), 32'(DEPTH));
    check(in_ready == 1'b0, "R6 full in_ready", 32'(in_ready), 32'd0);
    check(out_valid == 1'b1, "R6 full out_valid", 32'(out_valid), 32'd1);
    // stalled output must hold (R9)
    repeat (2) step(0, 0);
    // directed drain to empty
    repeat (4) step(0, 100);
    @(negedge clk);
    check(q.size() == 0, "R6 held after drain", 32'(q.size()), 32'd0);
    check(out_valid == 1'b0, "R6 empty out_valid", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R6 empty in_ready", 32'(in_ready), 32'd1);

    repeat (3000) step(90, 90);
    repeat (3000) step(30, 90);
    repeat (3000) step(90, 30);
    repeat (3000) step(100, 100);
    repeat (50) step(0, 100);
    @(negedge clk);
    check(q.size() < OUT_W, "R5 stream drained", 32'(q.size()), 32'(OUT_W - 1));
    check(out_valid == 1'b0, "R5 final out_valid", 32'(out_valid), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule